// File: doc/BRIEF.md
# Per-Port Interrupt Request Register Block

This block is the register front end of a 32-port vectored interrupt controller. Each port has an external, level-sensitive request line. The line passes through one flop, and the result is ORed with a software-trigger bit that software sets and clears. The ORed value is the port's raw status. A per-port enable masks the raw status, and the masked value is the pending flag that a downstream priority resolver consumes.

Each port also stores three attributes: a programmable level, a 6-bit register-set number and a non-maskable flag. These attributes go to the resolver together with a fixed 6-bit identifier for each port. Software reaches every register through a small memory-mapped slave port. Writes take effect at the clock edge. Read data returns one cycle after the read strobe and is marked by a valid pulse.

A two-state read machine sequences the slave port. IDLE moves to RESP on a read strobe. RESP returns to IDLE when no new read arrives, and stays in RESP when a back-to-back read arrives. Read data and the valid flag are presented in RESP.

Top module: `irqr_regblock`

## Requirements
- R1: Each external request line is registered once. A level sampled at clock edge k shows in the raw status and the pending output from edge k onward, and not earlier.
- R2: Writing the software-trigger register (word address 3, bit n for port n) raises port n's raw status even when its external line is low. The bit stays set until software writes it back to 0.
- R3: The pending flag of port n is raw status AND the enable bit (word address 1, bit n). A port whose enable bit is 0 never shows as pending.
- R4: Reset clears every enable, software-trigger, level, register-set and non-maskable register, and the input flop. After reset all pending flags and attribute outputs are zero.
- R5: Raw status (word address 0) and pending (word address 2) are read-only. Writes to them change no register and no output.
- R6: A read strobe at edge k makes read data and the valid flag appear after edge k for exactly one cycle. The valid flag is low in every cycle with no preceding read.
- R7: Port n's attribute word sits at word address 32+n. It holds the level in bits [3:0], the register-set number in bits [13:8] and the non-maskable flag in bit 16. Writes to it update port n's slices of the level, register-set and non-maskable outputs, and reads return these fields with all other bits zero.
- R8: The port identifier output carries the value n in the 6-bit slice of port n.
- R9: Word addresses 4 to 31 are unmapped. They read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 32 | External level-sensitive request lines |
| addr | input | 6 | Word address of the slave port |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid one cycle after the strobe |
| rd_valid | output | 1 | Read data valid |
| pend_o | output | 32 | Per-port pending flags |
| level_o | output | 128 | Per-port level, 4 bits per port |
| regset_o | output | 192 | Per-port register-set number, 6 bits per port |
| nmi_o | output | 32 | Per-port non-maskable flags |
| port_id_o | output | 192 | Per-port identifier, 6 bits per port |

## Verification
The pending logic is tried with four input patterns. The first is a hardware line with its enable both off and on, which separates the mask from the one-cycle input latency. The second is a software trigger with the line low, which shows that software alone can raise a port and that the bit holds until cleared. The third is writes to read-only and unmapped addresses, which shows that the raw and pending views are derived state with no storage behind them. The fourth is random line and enable patterns compared every clock against a behavioural model, which separates OR from AND combining and off-by-one port slicing.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
    localparam int A_RAW     = 0;
    localparam int A_ENABLE  = 1;
    localparam int A_PENDING = 2;
    localparam int A_SWTRIG  = 3;
    localparam int A_CFGBASE = 32;
    localparam int DATA_W    = 32;
    localparam int ID_W      = 6;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_t;
endpackage

// File: rtl/irqr_in_reg.sv
module irqr_in_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/irqr_port_cfg.sv
module irqr_port_cfg #(
    parameter int LVL_W = 4,
    parameter int RS_W  = 6,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_sel,
    input  logic [DW-1:0]    wr_data,
    output logic [LVL_W-1:0] level,
    output logic [RS_W-1:0]  regset,
    output logic             nmi,
    output logic [DW-1:0]    rd_word
);
    localparam int RS_LSB  = 8;
    localparam int NMI_BIT = 16;

    always_ff @(posedge clk) begin
        if (rst) begin
            level  <= '0;
            regset <= '0;
            nmi    <= 1'b0;
        end else if (wr_sel) begin
            level  <= wr_data[LVL_W-1:0];
            regset <= wr_data[RS_LSB +: RS_W];
            nmi    <= wr_data[NMI_BIT];
        end
    end

    always_comb begin
        rd_word                  = '0;
        rd_word[LVL_W-1:0]       = level;
        rd_word[RS_LSB +: RS_W]  = regset;
        rd_word[NMI_BIT]         = nmi;
    end
endmodule

// File: rtl/irqr_bus_fsm.sv
module irqr_bus_fsm
    import irqr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_mux,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    rd_state_t state, state_nx;
    logic [DATA_W-1:0] hold_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE: if (rd_en)  state_nx = RD_RESP;
            RD_RESP: if (!rd_en) state_nx = RD_IDLE;
            default: state_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RD_IDLE;
            hold_q <= '0;
        end else begin
            state <= state_nx;
            if (rd_en) hold_q <= rd_mux;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state)
            RD_IDLE: ;
            RD_RESP: begin
                rd_valid = 1'b1;
                rd_data  = hold_q;
            end
            default: ;
        endcase
    end

    p_valid_follows_read_r6: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    p_no_spurious_valid_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
endmodule

// File: rtl/irqr_regblock.sv
module irqr_regblock
    import irqr_pkg::*;
#(
    parameter int NPORT  = 32,
    parameter int LVL_W  = 4,
    parameter int RS_W   = 6,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORT-1:0]        irq_in,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    rd_en,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_valid,
    output logic [NPORT-1:0]        pend_o,
    output logic [NPORT*LVL_W-1:0]  level_o,
    output logic [NPORT*RS_W-1:0]   regset_o,
    output logic [NPORT-1:0]        nmi_o,
    output logic [NPORT*ID_W-1:0]   port_id_o
);
    logic [NPORT-1:0]  irq_q, en_q, sw_q, raw_w;
    logic [DATA_W-1:0] cfg_word [NPORT];
    logic [DATA_W-1:0] rd_mux;
    logic              cfg_hit;
    int                a_int, p_idx;

    irqr_in_reg #(.W(NPORT)) u_inreg (
        .clk(clk), .rst(rst), .d(irq_in), .q(irq_q)
    );

    assign raw_w  = irq_q | sw_q;
    assign pend_o = raw_w & en_q;

    always_comb begin
        a_int   = int'(addr);
        p_idx   = a_int - A_CFGBASE;
        cfg_hit = (a_int >= A_CFGBASE) && (p_idx < NPORT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            sw_q <= '0;
        end else if (wr_en) begin
            if (a_int == A_ENABLE) en_q <= wr_data[NPORT-1:0];
            if (a_int == A_SWTRIG) sw_q <= wr_data[NPORT-1:0];
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        logic sel;
        assign sel = wr_en && cfg_hit && (p_idx == i);
        irqr_port_cfg #(.LVL_W(LVL_W), .RS_W(RS_W), .DW(DATA_W)) u_cfg (
            .clk(clk), .rst(rst), .wr_sel(sel), .wr_data(wr_data),
            .level(level_o[i*LVL_W +: LVL_W]),
            .regset(regset_o[i*RS_W +: RS_W]),
            .nmi(nmi_o[i]),
            .rd_word(cfg_word[i])
        );
        assign port_id_o[i*ID_W +: ID_W] = ID_W'(i);
    end

    always_comb begin
        rd_mux = '0;
        if (cfg_hit) begin
            rd_mux = cfg_word[p_idx];
        end else begin
            case (a_int)
                A_RAW:     rd_mux[NPORT-1:0] = raw_w;
                A_ENABLE:  rd_mux[NPORT-1:0] = en_q;
                A_PENDING: rd_mux[NPORT-1:0] = pend_o;
                A_SWTRIG:  rd_mux[NPORT-1:0] = sw_q;
                default:   rd_mux = '0;
            endcase
        end
    end

    irqr_bus_fsm u_bus (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_mux(rd_mux),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    p_line_latency_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw_w & $past(irq_in)) == $past(irq_in)));
    p_sw_pends_r2: assert property (@(posedge clk) disable iff (rst)
        ((sw_q & en_q & ~pend_o) == '0));
    p_mask_r3: assert property (@(posedge clk) disable iff (rst)
        ((pend_o & ~en_q) == '0));
    p_reset_clear_r4: assert property (@(posedge clk)
        rst |=> (pend_o == '0 && en_q == '0 && sw_q == '0 && nmi_o == '0));
    p_ro_views_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (a_int == A_RAW || a_int == A_PENDING)) |=>
        ($stable(en_q) && $stable(sw_q) && $stable(level_o) && $stable(nmi_o)));
    p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && a_int > A_SWTRIG && a_int < A_CFGBASE) |=>
        ($stable(en_q) && $stable(sw_q) && $stable(regset_o)));
endmodule

// File: tb/sim_irqr_regblock.sv
module sim_irqr_regblock;
    localparam int NP = 32;
    localparam int LW = 4;
    localparam int RW = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   irq_in = '0;
    logic [5:0]      addr = '0;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd_data;
    logic            rd_valid;
    logic [NP-1:0]   pend_o, nmi_o;
    logic [NP*LW-1:0] level_o;
    logic [NP*RW-1:0] regset_o, port_id_o;

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 1'b0;

    // 250 MHz: 4-unit period
    always #2 clk = ~clk;

    irqr_regblock u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .pend_o(pend_o), .level_o(level_o), .regset_o(regset_o), .nmi_o(nmi_o),
        .port_id_o(port_id_o)
    );

    // behavioural reference
    bit [NP-1:0] m_line, m_en, m_sw;
    int          m_lvl [NP];
    int          m_rs  [NP];
    bit          m_nmi [NP];
    bit          m_rv;
    bit [31:0]   m_rd;

    function automatic bit [31:0] m_read(int a);
        bit [31:0] v = 0;
        if (a == 0) v[NP-1:0] = m_line | m_sw;
        else if (a == 1) v[NP-1:0] = m_en;
        else if (a == 2) v[NP-1:0] = (m_line | m_sw) & m_en;
        else if (a == 3) v[NP-1:0] = m_sw;
        else if (a >= 32 && a < 32 + NP)
            v = (m_nmi[a-32] ? 32'h1_0000 : 32'h0) | (32'(m_rs[a-32]) << 8) | 32'(m_lvl[a-32]);
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_line = '0; m_en = '0; m_sw = '0; m_rv = 0; m_rd = '0;
            for (int i = 0; i < NP; i++) begin m_lvl[i] = 0; m_rs[i] = 0; m_nmi[i] = 0; end
        end else begin
            m_rv = rd_en;
            if (rd_en) m_rd = m_read(int'(addr));
            if (wr_en) begin
                if (addr == 1) m_en = wr_data[NP-1:0];
                if (addr == 3) m_sw = wr_data[NP-1:0];
                if (addr >= 32) begin
                    m_lvl[addr-32] = int'(wr_data[3:0]);
                    m_rs[addr-32]  = int'(wr_data[13:8]);
                    m_nmi[addr-32] = wr_data[16];
                end
            end
            m_line = irq_in;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst && !finished) begin
            chk("R3 pending", pend_o, (m_line | m_sw) & m_en);
            chk("R6 valid", 32'(rd_valid), 32'(m_rv));
            if (m_rv) chk("R6 rdata", rd_data, m_rd);
            for (int i = 0; i < NP; i++) begin
                chk("R7 level", 32'(level_o[i*LW +: LW]), 32'(m_lvl[i]));
                chk("R7 regset", 32'(regset_o[i*RW +: RW]), 32'(m_rs[i]));
                chk("R7 nmi", 32'(nmi_o[i]), 32'(m_nmi[i]));
            end
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk); addr = 6'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk); addr = 6'(a); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R4 reset state
        chk("R4 pend", pend_o, 0);
        chk("R4 nmi", nmi_o, 0);
        chk("R4 level", 32'(|level_o), 0);
        rst = 1'b0;
        rd(1, v); chk("R4 enable read", v, 0);
        // R8 identifiers
        for (int i = 0; i < NP; i++) chk("R8 id", 32'(port_id_o[i*6 +: 6]), 32'(i));
        // R1 latency and R3 mask off
        @(negedge clk); irq_in = 32'h0000_0020;
        chk("R1 not before edge", pend_o, 0);
        @(negedge clk);
        chk("R3 masked", pend_o, 0);
        rd(0, v); chk("R1 raw", v, 32'h20);
        wr(1, 32'hFFFF_FFFF);
        chk("R3 enabled", pend_o, 32'h20);
        @(negedge clk); irq_in = '0;
        @(negedge clk); chk("R1 level drop", pend_o, 0);
        // R2 software trigger
        wr(3, 32'h0000_0200);
        repeat (5) @(negedge clk);
        chk("R2 held", pend_o, 32'h200);
        rd(3, v); chk("R2 read", v, 32'h200);
        wr(3, 0);
        chk("R2 cleared", pend_o, 0);
        // R5 read-only views
        wr(3, 32'h8000_0001);
        wr(0, 32'h0);
        wr(2, 32'h0);
        chk("R5 pend kept", pend_o, 32'h8000_0001);
        rd(3, v); chk("R5 sw kept", v, 32'h8000_0001);
        rd(2, v); chk("R5 pend read", v, 32'h8000_0001);
        // R7 attributes
        wr(32, 32'h0001_2A0F);
        wr(39, 32'h0000_0503);
        wr(63, 32'hFFFF_FFFF);
        rd(32, v); chk("R7 port0", v, 32'h0001_2A0F);
        rd(63, v); chk("R7 port31", v, 32'h0001_3F0F);
        chk("R7 lvl7", 32'(level_o[7*LW +: LW]), 3);
        chk("R7 rs7", 32'(regset_o[7*RW +: RW]), 5);
        // R9 unmapped
        wr(5, 32'hFFFF_FFFF);
        rd(5, v); chk("R9 read zero", v, 0);
        rd(1, v); chk("R9 enable kept", v, 32'hFFFF_FFFF);
        // back-to-back reads (R6)
        @(negedge clk); addr = 6'd1; rd_en = 1'b1;
        @(negedge clk); addr = 6'd3;
        chk("R6 b2b first", rd_data, 32'hFFFF_FFFF);
        @(negedge clk); rd_en = 1'b0;
        chk("R6 b2b second", rd_data, 32'h8000_0001);
        // random traffic checked by the model
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            irq_in = $urandom; wr_en = 1'b0; rd_en = 1'b0;
            if (k % 7 == 0) begin wr_en = 1'b1; addr = 6'(1 + 2 * ($urandom % 2)); wr_data = $urandom; end
            else if (k % 5 == 0) begin wr_en = 1'b1; addr = 6'(32 + $urandom % NP); wr_data = $urandom; end
            else if (k % 3 == 0) begin rd_en = 1'b1; addr = 6'($urandom % 64); end
        end
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; irq_in = '0;
        // R4 reset in operation
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R4 pend after reset", pend_o, 0);
        chk("R4 regset after reset", 32'(|regset_o), 0);
        rst = 1'b0;
        rd(3, v); chk("R4 sw after reset", v, 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule